// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is a transmit DMA sequencer. It works through a ring of descriptors kept in system memory. Each descriptor is four 32-bit words at a 16-byte stride. Software prepares a descriptor by filling in the buffer address and length and setting the ownership flag. It then writes the poll register. The engine reads the descriptor, streams the buffer out one byte at a time on a valid/ready interface, and writes the status word back in place. The written-back word clears ownership and reports whether the send was cut short.

After each descriptor the engine moves to the next one. If the descriptor carried the wrap mark, it returns to the ring base instead. It keeps going until it reads a descriptor that it does not own. A run bit gates the engine. When software clears the run bit, the engine finishes the frame in progress and then stops. The memory port uses single-word reads with a fixed one-cycle read latency, and single-word writes. The downstream consumer can abandon a segment through an abort input.

Top module: `txring_dma`

## Requirements
- R1: After reset the engine is idle: `tx_valid`, `mem_rd_en` and `mem_wr_en` are low, and they stay low until a poll write arrives while the run bit is set.
- R2: A write to register 1 (poll) is captured at a clock edge. The first descriptor read (word 0, at the current pointer) is issued in the cycle that follows the next edge. The first byte is valid 7 edges after the capture edge.
- R3: The bytes of a segment leave in ascending address order from the buffer address held in word 2, which may have any byte alignment. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of its word. Exactly the number of bytes in word 1 bits 10:0 is sent. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value.
- R4: `tx_first` marks the first byte of a descriptor whose word 1 bit 29 is set. `tx_last` marks the final byte of a descriptor whose word 1 bit 30 is set. The cycle after the final byte is accepted is a writeback cycle with `tx_valid` low.
- R5: Every owned descriptor produces exactly one single-cycle write to its word 0. The written value is 0x00000000, or 0x00008000 when the segment was aborted: bit 31 (ownership) is clear and bit 15 is the error flag. The engine then fetches the next descriptor at pointer+16 without a new poll.
- R6: After a descriptor with word 1 bit 25 set, the next fetch is at the ring base rather than pointer+16.
- R7: Word 1 bit 24 and word 3 have no effect on which descriptor is fetched next.
- R8: A fetched descriptor whose word 0 bit 31 is clear causes no byte and no write. The engine goes idle and keeps its pointer, and a later poll re-reads the same descriptor.
- R9: A descriptor with a byte count of zero sends no bytes and is still written back with ownership cleared.
- R10: When `tx_abort` is high in a sending cycle, no byte is transferred in that cycle and the rest of the segment is skipped. Word 0 is written back with bit 15 set, and the engine continues with the next descriptor.
- R11: Register 2 bit 0 is the run bit. When it is cleared during operation, the engine keeps fetching until it completes a descriptor with bit 30 set (or an aborted one), then idles. While the bit is clear, an idle engine stays idle, even after a poll.
- R12: A write to register 0 sets the ring base (bits 3:0 forced to zero). If the engine is idle, the write also moves the current pointer to the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 poll, 2 run |
| reg_wdata | input | 32 | Register write data |
| mem_rd_en | output | 1 | Memory word read request |
| mem_wr_en | output | 1 | Memory word write request |
| mem_addr | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Consumer accepts byte |
| tx_data | output | 8 | Byte value |
| tx_first | output | 1 | First byte of a first-segment descriptor |
| tx_last | output | 1 | Final byte of a last-segment descriptor |
| tx_abort | input | 1 | Consumer abandons the current segment |

## Verification
Descriptor timing is fixed relative to the poll write. The first word-0 read is due one edge after the capture edge and the first byte seven edges after it. A dedicated probe counts falling edges from the write and compares both counts. Bytes and writebacks have no fixed offset under random backpressure, so the reference model orders them instead: it builds the expected byte and writeback sequence from its own copy of memory. On every falling edge where a handshake or a write is about to take effect at the next rising edge, the bench compares it against the head of that sequence. Anything that appears in an idle phase is therefore reported at once. The abort is raised from the edge after the chosen byte is accepted, so the bench knows exactly which bytes precede the error writeback.

// File: rtl/txring_pkg.sv
`timescale 1ns/1ps
package txring_pkg;
    localparam int OWN_BIT   = 31;
    localparam int ERR_BIT   = 15;
    localparam int LAST_BIT  = 30;
    localparam int FIRST_BIT = 29;
    localparam int WRAP_BIT  = 25;
    localparam int LEN_W     = 11;
    localparam int DESC_BYTES = 16;

    typedef enum logic [1:0] {
        RA_BASE = 2'd0,
        RA_POLL = 2'd1,
        RA_RUN  = 2'd2
    } reg_addr_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_LWAIT,
        ST_SEND,
        ST_WBACK
    } seq_state_e;

    typedef struct packed {
        logic             last_seg;
        logic             first_seg;
        logic             wrap;
        logic [LEN_W-1:0] len;
    } ctl_t;

    function automatic ctl_t decode_ctl(input logic [31:0] w);
        ctl_t c;
        c.last_seg  = w[LAST_BIT];
        c.first_seg = w[FIRST_BIT];
        c.wrap      = w[WRAP_BIT];
        c.len       = w[LEN_W-1:0];
        return c;
    endfunction

    function automatic logic [31:0] status_word(input logic err);
        logic [31:0] s;
        s = '0;
        s[ERR_BIT] = err;
        return s;
    endfunction
endpackage

// File: rtl/txring_csr.sv
`timescale 1ns/1ps
module txring_csr import txring_pkg::*; #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              fetch_start,
    output logic [ADDR_W-1:0] base_addr,
    output logic              base_load,
    output logic              run_en,
    output logic              poll_pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_load <= 1'b0;
            run_en    <= 1'b0;
            poll_pend <= 1'b0;
        end else begin
            base_load <= 1'b0;
            if (wr_en && wr_addr == RA_BASE) begin
                base_addr <= {wr_data[ADDR_W-1:4], 4'b0000};
                base_load <= 1'b1;
            end
            if (wr_en && wr_addr == RA_RUN)
                run_en <= wr_data[0];
            if (wr_en && wr_addr == RA_POLL)
                poll_pend <= 1'b1;
            else if (fetch_start)
                poll_pend <= 1'b0;
        end
    end

    // R2
    poll_seen_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == RA_POLL) |=> poll_pend);
endmodule

// File: rtl/txring_lane.sv
`timescale 1ns/1ps
module txring_lane (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] word_in,
    input  logic [1:0]  sel,
    output logic [7:0]  byte_out
);
    logic [31:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)       word_q <= '0;
        else if (load) word_q <= word_in;
    end

    always_comb begin
        case (sel)
            2'd0:    byte_out = word_q[7:0];
            2'd1:    byte_out = word_q[15:8];
            2'd2:    byte_out = word_q[23:16];
            default: byte_out = word_q[31:24];
        endcase
    end
endmodule

// File: rtl/txring_seq.sv
`timescale 1ns/1ps
module txring_seq import txring_pkg::*; #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              base_load,
    input  logic              run_en,
    input  logic              poll_pend,
    output logic              fetch_start,
    output logic              idle,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              lane_load,
    output logic [1:0]        lane_sel,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_first,
    output logic              tx_last,
    input  logic              tx_abort
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_BYTES);

    seq_state_e       st;
    logic [1:0]       fcnt;
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] bptr;
    logic             own_q;
    ctl_t             ctl_q;
    logic [LEN_W-1:0] left;
    logic             err_q;
    logic             frame_end;
    logic             go_on;

    assign frame_end = ctl_q.last_seg || err_q;
    assign go_on     = run_en || !frame_end;

    assign fetch_start = (st == ST_IDLE && !base_load && poll_pend && run_en)
                      || (st == ST_WBACK && go_on);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            fcnt  <= '0;
            cur   <= '0;
            bptr  <= '0;
            own_q <= 1'b0;
            ctl_q <= '0;
            left  <= '0;
            err_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (base_load) begin
                        cur <= base_addr;
                    end else if (poll_pend && run_en) begin
                        st   <= ST_FETCH;
                        fcnt <= '0;
                    end
                end
                ST_FETCH: begin
                    fcnt <= fcnt + 2'd1;
                    case (fcnt)
                        2'd1: own_q <= mem_rdata[OWN_BIT];
                        2'd2: ctl_q <= decode_ctl(mem_rdata);
                        2'd3: begin
                            bptr  <= mem_rdata[ADDR_W-1:0];
                            left  <= ctl_q.len;
                            err_q <= 1'b0;
                            if (!own_q)               st <= ST_IDLE;
                            else if (ctl_q.len == '0) st <= ST_WBACK;
                            else                      st <= ST_LOAD;
                        end
                        default: ;
                    endcase
                end
                ST_LOAD:  st <= ST_LWAIT;
                ST_LWAIT: st <= ST_SEND;
                ST_SEND: begin
                    if (tx_abort) begin
                        err_q <= 1'b1;
                        st    <= ST_WBACK;
                    end else if (tx_ready) begin
                        left <= left - 1'b1;
                        bptr <= bptr + 1'b1;
                        if (left == 1)              st <= ST_WBACK;
                        else if (bptr[1:0] == 2'b11) st <= ST_LOAD;
                    end
                end
                ST_WBACK: begin
                    cur <= ctl_q.wrap ? base_addr : cur + STRIDE;
                    if (go_on) begin
                        st   <= ST_FETCH;
                        fcnt <= '0;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (st)
            ST_FETCH: mem_addr = cur + ADDR_W'({fcnt, 2'b00});
            ST_LOAD:  mem_addr = {bptr[ADDR_W-1:2], 2'b00};
            default:  mem_addr = cur;
        endcase
    end

    assign mem_rd_en = (st == ST_FETCH && fcnt != 2'd3) || st == ST_LOAD;
    assign mem_wr_en = (st == ST_WBACK);
    assign mem_wdata = status_word(err_q);
    assign lane_load = (st == ST_LWAIT);
    assign lane_sel  = bptr[1:0];
    assign idle      = (st == ST_IDLE);
    assign tx_valid  = (st == ST_SEND) && !tx_abort;
    assign tx_first  = tx_valid && ctl_q.first_seg && (left == ctl_q.len);
    assign tx_last   = tx_valid && ctl_q.last_seg && (left == 1);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!tx_valid && !mem_rd_en && !mem_wr_en));

    // R4
    last_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> (mem_wr_en && !tx_valid));

    // R5
    wb_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> !mem_wr_en);

    // R5
    wb_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> !mem_rd_en);
endmodule

// File: rtl/txring_dma.sv
`timescale 1ns/1ps
module txring_dma import txring_pkg::*; #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_first,
    output logic              tx_last,
    input  logic              tx_abort
);
    logic [ADDR_W-1:0] base_addr;
    logic              base_load;
    logic              run_en;
    logic              poll_pend;
    logic              fetch_start;
    logic              idle;
    logic              lane_load;
    logic [1:0]        lane_sel;

    txring_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .fetch_start(fetch_start),
        .base_addr(base_addr), .base_load(base_load),
        .run_en(run_en), .poll_pend(poll_pend)
    );

    txring_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst),
        .base_addr(base_addr), .base_load(base_load),
        .run_en(run_en), .poll_pend(poll_pend),
        .fetch_start(fetch_start), .idle(idle),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .lane_load(lane_load), .lane_sel(lane_sel),
        .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_first(tx_first), .tx_last(tx_last), .tx_abort(tx_abort)
    );

    txring_lane u_lane (
        .clk(clk), .rst(rst),
        .load(lane_load), .word_in(mem_rdata),
        .sel(lane_sel), .byte_out(tx_data)
    );

    // R11
    stopped_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && !run_en) |=> idle);

    // R3
    hold_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_abort || (tx_valid && $stable(tx_data))));
endmodule

// File: tb/txring_dma_test.sv
`timescale 1ns/1ps
module txring_dma_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        mem_rd_en, mem_wr_en;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'd0;
    logic        tx_valid, tx_first, tx_last;
    logic        tx_ready = 1'b1;
    logic        tx_abort = 1'b0;
    logic [7:0]  tx_data;

    always #4 clk = ~clk;

    txring_dma uut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last), .tx_abort(tx_abort)
    );

    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] LS  = 32'h4000_0000;
    localparam logic [31:0] FS  = 32'h2000_0000;
    localparam logic [31:0] EOR = 32'h0200_0000;
    localparam logic [31:0] CHN = 32'h0100_0000;

    logic [31:0] mem  [0:255];
    logic [31:0] refm [0:255];

    int n_tests = 0;
    int n_fail  = 0;
    logic [9:0]  exp_b [$];
    logic [63:0] exp_w [$];
    int byte_cnt = 0;
    int push_cnt = 0;
    int abort_target = 0;
    bit abort_armed = 1'b0;
    bit bp_on = 1'b0;
    int cyc = 0;
    logic [31:0] m_cur = 32'd0;
    logic [31:0] m_base = 32'd0;
    bit m_run = 1'b0;
    logic [31:0] ab_desc = 32'd0;
    int ab_idx = -1;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[9:2]];
        if (mem_wr_en) mem[mem_addr[9:2]] <= mem_wdata;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        tx_ready <= bp_on ? ((cyc % 3) != 0) : 1'b1;
        tx_abort <= abort_armed && (byte_cnt == abort_target);
    end

    // compare against the reference sequence before each edge takes effect
    always @(negedge clk) begin : cmp_blk
        logic [9:0]  eb;
        logic [63:0] ew;
        if (!rst) begin
            if (tx_valid && tx_ready) begin
                if (exp_b.size() == 0) begin
                    check(1'b0, "R3 unexpected byte", {56'd0, tx_data}, 64'd0);
                end else begin
                    eb = exp_b.pop_front();
                    check(tx_data == eb[7:0], "R3 byte value", {56'd0, tx_data}, {56'd0, eb[7:0]});
                    check(tx_first == eb[9], "R4 first mark", {63'd0, tx_first}, {63'd0, eb[9]});
                    check(tx_last == eb[8], "R4 last mark", {63'd0, tx_last}, {63'd0, eb[8]});
                end
                byte_cnt++;
            end
            if (mem_wr_en) begin
                if (exp_w.size() == 0) begin
                    check(1'b0, "R5 unexpected writeback", {mem_addr, mem_wdata}, 64'd0);
                end else begin
                    ew = exp_w.pop_front();
                    check({mem_addr, mem_wdata} == ew, "R5 writeback", {mem_addr, mem_wdata}, ew);
                end
                if (mem_wdata[15]) abort_armed = 1'b0;
            end
        end
    end

    task automatic put_word(input logic [31:0] a, input logic [31:0] v);
        mem[a[9:2]] <= v;
        refm[a[9:2]] = v;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3);
        put_word(a, w0);
        put_word(a + 4, w1);
        put_word(a + 8, w2);
        put_word(a + 12, w3);
    endtask

    function automatic logic [7:0] ref_byte(input logic [31:0] a);
        logic [31:0] w;
        w = refm[a[9:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    // reference walk of the ring over the model's own memory copy
    task automatic model_walk();
        logic [31:0] w0, w1, w2, a;
        int n;
        bit err, fin;
        for (int g = 0; g < 16; g++) begin
            w0 = refm[m_cur[9:2]];
            if (!w0[31]) break;
            w1 = refm[m_cur[9:2] + 8'd1];
            w2 = refm[m_cur[9:2] + 8'd2];
            n = int'(w1[10:0]);
            err = 1'b0;
            for (int i = 0; i < n; i++) begin
                if (ab_idx >= 0 && m_cur == ab_desc && i == ab_idx) begin
                    err = 1'b1;
                    abort_target = push_cnt;
                    abort_armed = 1'b1;
                    break;
                end
                a = w2 + i;
                exp_b.push_back({w1[29] && i == 0, w1[30] && i == n - 1, ref_byte(a)});
                push_cnt++;
            end
            exp_w.push_back({m_cur, err ? 32'h0000_8000 : 32'h0});
            refm[m_cur[9:2]] = err ? 32'h0000_8000 : 32'h0;
            if (err) ab_idx = -1;
            fin = w1[30] || err;
            m_cur = w1[25] ? m_base : m_cur + 16;
            if (!m_run && fin) break;
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic wait_quiet();
        int q;
        q = 0;
        while (q < 20) begin
            @(negedge clk);
            if (mem_rd_en || mem_wr_en || tx_valid) q = 0;
            else q++;
        end
    endtask

    task automatic phase_end(input string tag);
        wait_quiet();
        check(exp_b.size() == 0, {tag, " bytes outstanding"}, 64'(exp_b.size()), 64'd0);
        check(exp_w.size() == 0, {tag, " writebacks outstanding"}, 64'(exp_w.size()), 64'd0);
        for (int k = 0; k < 8; k++) begin
            logic [31:0] a;
            a = 32'h100 + 32'(k * 16);
            check(mem[a[9:2]] == refm[a[9:2]], {tag, " R5 descriptor word 0"},
                  {32'd0, mem[a[9:2]]}, {32'd0, refm[a[9:2]]});
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int lat, rd_c;
        logic [31:0] rd_a;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 32'd0;
            refm[i] = 32'd0;
        end
        for (int k = 0; k < 64; k++) begin
            logic [31:0] v;
            for (int b = 0; b < 4; b++) v[8*b +: 8] = 8'((4 * k + b) * 13 + 5);
            put_word(32'h200 + 32'(4 * k), v);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: idle after reset with nothing requested
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            check(!tx_valid && !mem_rd_en && !mem_wr_en, "R1 reset idle",
                  {61'd0, tx_valid, mem_rd_en, mem_wr_en}, 64'd0);
        end

        // R12 base, R11 run; R8 unowned descriptor
        reg_write(2'd0, 32'h0000_0105);
        m_base = 32'h100; m_cur = 32'h100;
        reg_write(2'd2, 32'd1);
        m_run = 1'b1;
        put_desc(32'h100, 32'h0, FS | LS | 32'd5, 32'h200, 32'h0);
        reg_write(2'd1, 32'd1);
        phase_end("R8 unowned");

        // R2 latency, R8 same descriptor re-read
        put_desc(32'h100, OWN, FS | LS | 32'd5, 32'h200, 32'h0);
        model_walk();
        reg_write(2'd1, 32'd1);
        lat = 0; rd_c = 0; rd_a = 32'd0;
        for (int c = 1; c <= 20; c++) begin
            @(negedge clk);
            if (mem_rd_en && rd_c == 0) begin rd_c = c; rd_a = mem_addr; end
            if (tx_valid) begin lat = c; break; end
        end
        check(rd_c == 1, "R2 first read cycle", 64'(rd_c), 64'd1);
        check(rd_a == 32'h100, "R8 re-read same descriptor", {32'd0, rd_a}, 64'h100);
        check(lat == 7, "R2 first byte latency", 64'(lat), 64'd7);
        phase_end("R2 single");

        // R3 unaligned with backpressure, R7 chain bit ignored, R9 zero count, R6 wrap
        bp_on = 1'b1;
        put_desc(32'h300, OWN, FS | LS | 32'd2, 32'h280, 32'h0);
        put_desc(32'h110, OWN, FS | CHN | 32'd9, 32'h213, 32'h300);
        put_desc(32'h120, OWN, LS | EOR | 32'd0, 32'h2f0, 32'h0);
        model_walk();
        reg_write(2'd1, 32'd1);
        phase_end("R7 R9 R6 ring");
        check(m_cur == 32'h100, "R6 model pointer wrapped", {32'd0, m_cur}, 64'h100);

        // R10 abort mid segment, later descriptor still sent
        put_desc(32'h100, OWN, FS | LS | 32'd6, 32'h240, 32'h0);
        put_desc(32'h110, OWN, FS | LS | 32'd8, 32'h250, 32'h0);
        put_desc(32'h120, OWN, FS | LS | EOR | 32'd4, 32'h262, 32'h0);
        ab_desc = 32'h110; ab_idx = 3;
        model_walk();
        reg_write(2'd1, 32'd1);
        phase_end("R10 abort");
        check(byte_cnt == push_cnt, "R10 byte total", 64'(byte_cnt), 64'(push_cnt));

        // R11 run cleared mid frame: finish frame then idle
        bp_on = 1'b0;
        put_desc(32'h100, OWN, FS | 32'd3, 32'h270, 32'h0);
        put_desc(32'h110, OWN, LS | 32'd2, 32'h278, 32'h0);
        put_desc(32'h120, OWN, FS | LS | EOR | 32'd2, 32'h27c, 32'h0);
        m_run = 1'b0;
        model_walk();
        reg_write(2'd1, 32'd1);
        reg_write(2'd2, 32'd0);
        phase_end("R11 stop");
        reg_write(2'd1, 32'd1);
        phase_end("R11 poll while stopped");
        m_run = 1'b1;
        model_walk();
        reg_write(2'd2, 32'd1);
        phase_end("R11 resume");

        // R12 new base while idle
        put_desc(32'h180, OWN, FS | LS | EOR | 32'd5, 32'h2a1, 32'h0);
        reg_write(2'd0, 32'h0000_0180);
        m_base = 32'h180; m_cur = 32'h180;
        model_walk();
        reg_write(2'd1, 32'd1);
        phase_end("R12 base");
        check(mem[8'h60] == 32'h0, "R12 writeback at new base", {32'd0, mem[8'h60]}, 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule